// File: doc/BRIEF.md
# Single-Channel Transfer Engine

This block is one self-contained transfer channel. It moves units of 1, 2 or 4 bytes between a range of memory and a device register through a single-beat bus master port. Software fills a small register file with a live memory pointer, a memory limit, a device pointer, a control word, an activate bit, sticky status and interrupt enables. The channel then moves one unit at a time until the memory pointer equals the limit. No byte count is kept. The number of bytes left is always the limit minus the live pointer.

A channel can be paced in two ways. With hardware pacing, each rising edge of a device request input moves exactly one unit. With software pacing, units follow each other back to back. A transfer can end in one of five ways: normal completion, a bus error, an abort at a unit boundary, a device terminate, or an immediate stop when the activate bit or the selected run bit is cleared. Completion and bus error can raise the interrupt output.

Top module: `xfer_channel`

## Requirements
- R1: When the memory pointer, stepped after a good write beat, equals the memory limit (register index 1), the channel goes idle. Busy (control bit 17) reads 0, the done status (bit 2) is set, and both run bits (control bits 0 and 1) are cleared.
- R2: Each unit is a read beat and then a write beat. `m_req` stays high on each beat until `m_ack`. With direction (control bit 2) at 1, the read uses the memory pointer (index 0) and the write uses the device pointer (index 2). With direction at 0, the two addresses are swapped.
- R3: Control bit 3 lets the memory pointer advance and control bit 4 lets the device pointer advance. When a bit is 0, that pointer keeps its value across units.
- R4: Control field [10:8] selects the unit size: 2 gives 2 bytes and 4 gives 4 bytes. Any other value gives 1 byte. `m_size` is 0, 1 or 2 for 1, 2 or 4 bytes, and each advancing pointer steps by the unit size.
- R5: Control bit 5 at 1 selects software pacing, run bit 1, with units back to back. At 0 it selects hardware pacing, run bit 0, where no unit starts until `dev_req` rises and each rise starts one unit. Clearing the selected run bit stops the channel in the next cycle.
- R6: Writing 1 to control bit 16 while busy ends the transfer once the unit in flight completes. Done is not set and the pointer is left on a unit boundary.
- R7: Status (index 5) holds bus error in bit 0, request overflow in bit 1, done in bit 2 and terminate in bit 3. All bits are 0 after reset. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` = (done AND enable bit 0) OR (bus error AND enable bit 1), where the enables are at index 6. Overflow and terminate never drive `irq`.
- R9: Index 7 reads the memory limit minus the memory pointer when the limit is greater, and 0 otherwise.
- R10: While activate (index 4, bit 0) is 0, no beat is issued. Clearing activate drops `m_req` in the next cycle. Setting it again resumes the transfer from the live pointer.
- R11: A beat acknowledged with `m_err` ends the transfer. It sets bus error, clears busy, leaves done clear and does not advance the pointers.
- R12: Under hardware pacing, a `dev_req` rise while a unit is in flight sets overflow and does not start an extra unit.
- R13: Under hardware pacing, `dev_term` ends the transfer at the next unit boundary and sets terminate status without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Bus beat request, held until acknowledged |
| m_we | output | 1 | Beat is a write |
| m_addr | output | AW | Beat byte address |
| m_size | output | 2 | Unit size code |
| m_wdata | output | 32 | Write data, unit in the low bytes |
| m_ack | input | 1 | Beat acknowledge |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| m_err | input | 1 | Error response, valid with `m_ack` |
| dev_req | input | 1 | Device pacing request |
| dev_term | input | 1 | Device terminate request |
| irq | output | 1 | Interrupt |

## Verification
Most engine faults show up in memory. A bad pointer step or a swapped direction puts wrong bytes at the destination, and the bench sees this as soon as the transfer ends. A bad completion compare either runs past the limit or stalls with busy high, and both are caught by the read-back of the pointer and busy. Pacing faults show up within a few cycles as pointer movement before any request, or as a missing or extra overflow bit. Stop paths are checked one cycle after the stop, through `m_req` and busy.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int DW = 32;

    // register indices
    typedef enum logic [2:0] {
        RA_MPTR = 3'd0,
        RA_MLIM = 3'd1,
        RA_DPTR = 3'd2,
        RA_CTRL = 3'd3,
        RA_ACT  = 3'd4,
        RA_STAT = 3'd5,
        RA_IEN  = 3'd6,
        RA_REM  = 3'd7
    } raddr_e;

    // control word bit positions
    localparam int CB_RUNHW   = 0;
    localparam int CB_RUNSW   = 1;
    localparam int CB_M2D     = 2;
    localparam int CB_INCM    = 3;
    localparam int CB_INCD    = 4;
    localparam int CB_SWSEL   = 5;
    localparam int CB_UNIT_LO = 8;
    localparam int CB_ABORT   = 16;
    localparam int CB_BUSY    = 17;

    // status bit positions
    localparam int SB_BERR = 0;
    localparam int SB_OVF  = 1;
    localparam int SB_DONE = 2;
    localparam int SB_TERM = 3;

    // interrupt enable bit positions
    localparam int EB_DONE = 0;
    localparam int EB_BERR = 1;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } fsm_e;

    typedef struct packed {
        logic       run_hw;
        logic       run_sw;
        logic       m2d;
        logic       inc_mem;
        logic       inc_dev;
        logic       sw_sel;
        logic [2:0] unit;
    } ctrl_t;

    function automatic unit_e unit_code(input logic [2:0] f);
        case (f)
            3'd2:    return SZ_H;
            3'd4:    return SZ_W;
            default: return SZ_B;
        endcase
    endfunction

    function automatic logic [2:0] unit_bytes(input unit_e u);
        case (u)
            SZ_H:    return 3'd2;
            SZ_W:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          busy,
    input  logic          step,
    input  logic          clr_run,
    input  logic [3:0]    st_set,
    output ctrl_t         ctrl,
    output logic          active,
    output logic          abort_req,
    output logic [AW-1:0] mem_ptr,
    output logic [AW-1:0] mem_lim,
    output logic [AW-1:0] dev_ptr,
    output logic [AW-1:0] mem_nxt,
    output logic [3:0]    status,
    output logic [1:0]    ien,
    output logic          irq
);

    localparam int PADW = AW - 3;

    raddr_e        ra;
    logic [2:0]    sb;
    logic [AW-1:0] stepw;
    logic [AW-1:0] dev_nxt;
    logic [AW-1:0] remain;
    logic [3:0]    st_clr;

    assign ra      = raddr_e'(addr);
    assign sb      = unit_bytes(unit_code(ctrl.unit));
    assign stepw   = {{PADW{1'b0}}, sb};
    assign mem_nxt = mem_ptr + (ctrl.inc_mem ? stepw : '0);
    assign dev_nxt = dev_ptr + (ctrl.inc_dev ? stepw : '0);
    assign remain  = (mem_lim > mem_ptr) ? (mem_lim - mem_ptr) : '0;
    assign st_clr  = (we && ra == RA_STAT) ? wdata[3:0] : 4'd0;
    assign irq     = (status[SB_DONE] & ien[EB_DONE]) | (status[SB_BERR] & ien[EB_BERR]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ptr   <= '0;
            mem_lim   <= '0;
            dev_ptr   <= '0;
            ctrl      <= '0;
            active    <= 1'b0;
            abort_req <= 1'b0;
            status    <= '0;
            ien       <= '0;
        end else begin
            // engine stepping wins over a software write in the same cycle
            if (step)                        mem_ptr <= mem_nxt;
            else if (we && ra == RA_MPTR)    mem_ptr <= wdata[AW-1:0];
            if (step)                        dev_ptr <= dev_nxt;
            else if (we && ra == RA_DPTR)    dev_ptr <= wdata[AW-1:0];
            if (we && ra == RA_MLIM)         mem_lim <= wdata[AW-1:0];
            if (we && ra == RA_ACT)          active  <= wdata[0];
            if (we && ra == RA_IEN)          ien     <= wdata[1:0];

            if (we && ra == RA_CTRL) begin
                ctrl.run_hw  <= wdata[CB_RUNHW];
                ctrl.run_sw  <= wdata[CB_RUNSW];
                ctrl.m2d     <= wdata[CB_M2D];
                ctrl.inc_mem <= wdata[CB_INCM];
                ctrl.inc_dev <= wdata[CB_INCD];
                ctrl.sw_sel  <= wdata[CB_SWSEL];
                ctrl.unit    <= wdata[CB_UNIT_LO +: 3];
                if (busy) abort_req <= wdata[CB_ABORT];
            end
            if (clr_run) begin
                ctrl.run_hw <= 1'b0;
                ctrl.run_sw <= 1'b0;
            end
            if (clr_run || !busy) abort_req <= 1'b0;

            // a hardware set wins over a write-one-to-clear
            status <= (status & ~st_clr) | st_set;
        end
    end

    always_comb begin
        rdata = '0;
        case (ra)
            RA_MPTR: rdata[AW-1:0] = mem_ptr;
            RA_MLIM: rdata[AW-1:0] = mem_lim;
            RA_DPTR: rdata[AW-1:0] = dev_ptr;
            RA_CTRL: begin
                rdata[CB_RUNHW]        = ctrl.run_hw;
                rdata[CB_RUNSW]        = ctrl.run_sw;
                rdata[CB_M2D]          = ctrl.m2d;
                rdata[CB_INCM]         = ctrl.inc_mem;
                rdata[CB_INCD]         = ctrl.inc_dev;
                rdata[CB_SWSEL]        = ctrl.sw_sel;
                rdata[CB_UNIT_LO +: 3] = ctrl.unit;
                rdata[CB_ABORT]        = abort_req;
                rdata[CB_BUSY]         = busy;
            end
            RA_ACT:  rdata[0]      = active;
            RA_STAT: rdata[3:0]    = status;
            RA_IEN:  rdata[1:0]    = ien;
            RA_REM:  rdata[AW-1:0] = remain;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/xfer_pacer.sv
module xfer_pacer (
    input  logic clk,
    input  logic rst,
    input  logic dev_req,
    input  logic dev_term,
    input  logic busy,
    input  logic hw_mode,
    input  logic in_flight,
    input  logic clr_run,
    output logic req_rise,
    output logic term_now,
    output logic ovf_evt
);

    logic req_q;
    logic term_q;
    logic term_in;

    assign term_in  = busy & hw_mode & dev_term;
    assign req_rise = dev_req & ~req_q;
    assign ovf_evt  = req_rise & in_flight & hw_mode & busy;
    assign term_now = term_q | term_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            term_q <= 1'b0;
        end else begin
            req_q <= dev_req;
            if (clr_run || !busy) term_q <= 1'b0;
            else if (term_in)     term_q <= 1'b1;
        end
    end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          active,
    input  logic          abort_req,
    input  logic [AW-1:0] mem_ptr,
    input  logic [AW-1:0] mem_lim,
    input  logic [AW-1:0] dev_ptr,
    input  logic [AW-1:0] mem_nxt,
    input  logic          req_rise,
    input  logic          term_now,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output unit_e         m_size,
    output logic [DW-1:0] m_wdata,
    output logic          busy,
    output logic          in_flight,
    output logic          hw_mode,
    output logic          step,
    output logic          clr_run,
    output logic [3:0]    st_set
);

    fsm_e          state, nxt;
    logic          go;
    logic          cap;
    logic [DW-1:0] data_q;

    assign hw_mode   = ~ctrl.sw_sel;
    assign go        = active && (ctrl.sw_sel ? ctrl.run_sw : ctrl.run_hw);
    assign busy      = (state != ST_IDLE);
    assign in_flight = (state == ST_RD) || (state == ST_WR);
    assign m_req     = in_flight;
    assign m_we      = (state == ST_WR);
    assign m_size    = unit_code(ctrl.unit);
    assign m_wdata   = data_q;
    assign m_addr    = ((state == ST_RD) == ctrl.m2d) ? mem_ptr : dev_ptr;

    always_comb begin
        nxt     = state;
        cap     = 1'b0;
        step    = 1'b0;
        clr_run = 1'b0;
        st_set  = '0;
        case (state)
            ST_IDLE: begin
                if (go && mem_ptr != mem_lim) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (!go) begin
                    nxt = ST_IDLE;
                end else if (abort_req) begin
                    nxt     = ST_IDLE;
                    clr_run = 1'b1;
                end else if (hw_mode && term_now) begin
                    nxt             = ST_IDLE;
                    clr_run         = 1'b1;
                    st_set[SB_TERM] = 1'b1;
                end else if (!hw_mode || req_rise) begin
                    nxt = ST_RD;
                end
            end
            ST_RD: begin
                if (!go) begin
                    nxt = ST_IDLE;
                end else if (m_ack) begin
                    if (m_err) begin
                        nxt             = ST_IDLE;
                        clr_run         = 1'b1;
                        st_set[SB_BERR] = 1'b1;
                    end else begin
                        cap = 1'b1;
                        nxt = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (!go) begin
                    nxt = ST_IDLE;
                end else if (m_ack) begin
                    if (m_err) begin
                        nxt             = ST_IDLE;
                        clr_run         = 1'b1;
                        st_set[SB_BERR] = 1'b1;
                    end else begin
                        step = 1'b1;
                        if (mem_nxt == mem_lim) begin
                            nxt             = ST_IDLE;
                            clr_run         = 1'b1;
                            st_set[SB_DONE] = 1'b1;
                        end else if (abort_req) begin
                            nxt     = ST_IDLE;
                            clr_run = 1'b1;
                        end else if (hw_mode && term_now) begin
                            nxt             = ST_IDLE;
                            clr_run         = 1'b1;
                            st_set[SB_TERM] = 1'b1;
                        end else begin
                            nxt = hw_mode ? ST_WAIT : ST_RD;
                        end
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (cap) data_q <= m_rdata;
        end
    end

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
    import xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [31:0]   m_wdata,
    input  logic          m_ack,
    input  logic [31:0]   m_rdata,
    input  logic          m_err,
    input  logic          dev_req,
    input  logic          dev_term,
    output logic          irq
);

    ctrl_t         ctrl;
    logic          active;
    logic          abort_req;
    logic [AW-1:0] mem_ptr, mem_lim, dev_ptr, mem_nxt;
    logic [3:0]    status;
    logic [1:0]    ien;
    logic          busy, in_flight, hw_mode, step, clr_run;
    logic [3:0]    eng_set, st_set;
    logic          req_rise, term_now, ovf_evt;
    unit_e         eng_size;

    assign st_set = eng_set | ({3'd0, ovf_evt} << SB_OVF);
    assign m_size = eng_size;

    xfer_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .step(step), .clr_run(clr_run),
        .st_set(st_set), .ctrl(ctrl), .active(active), .abort_req(abort_req),
        .mem_ptr(mem_ptr), .mem_lim(mem_lim), .dev_ptr(dev_ptr), .mem_nxt(mem_nxt),
        .status(status), .ien(ien), .irq(irq)
    );

    xfer_pacer u_pacer (
        .clk(clk), .rst(rst), .dev_req(dev_req), .dev_term(dev_term),
        .busy(busy), .hw_mode(hw_mode), .in_flight(in_flight), .clr_run(clr_run),
        .req_rise(req_rise), .term_now(term_now), .ovf_evt(ovf_evt)
    );

    xfer_engine #(.AW(AW)) u_engine (
        .clk(clk), .rst(rst), .ctrl(ctrl), .active(active), .abort_req(abort_req),
        .mem_ptr(mem_ptr), .mem_lim(mem_lim), .dev_ptr(dev_ptr), .mem_nxt(mem_nxt),
        .req_rise(req_rise), .term_now(term_now), .m_ack(m_ack), .m_err(m_err),
        .m_rdata(m_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_size(eng_size), .m_wdata(m_wdata), .busy(busy), .in_flight(in_flight),
        .hw_mode(hw_mode), .step(step), .clr_run(clr_run), .st_set(eng_set)
    );

endmodule

// File: rtl/xfer_channel_chk.sv
module xfer_channel_chk (
    input logic       clk,
    input logic       rst,
    input logic       m_req,
    input logic       m_ack,
    input logic       m_err,
    input logic       busy,
    input logic       active,
    input logic       irq,
    input logic [1:0] m_size,
    input logic [1:0] ien,
    input logic [3:0] status
);

    // R11
    berr_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_ack && m_err) |=> !busy);

    // R10
    deact_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !m_req);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> !busy);

    // R4
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        m_req |-> (m_size != 2'd3));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq);

endmodule

bind xfer_channel xfer_channel_chk u_chk (
    .clk(clk), .rst(rst), .m_req(m_req), .m_ack(m_ack), .m_err(m_err),
    .busy(busy), .active(active), .irq(irq), .m_size(m_size), .ien(ien),
    .status(status)
);

// File: tb/xfer_channel_bench.sv
module xfer_channel_bench;

    localparam logic [31:0] RUNHW = 32'h1,  RUNSW = 32'h2,  M2D = 32'h4;
    localparam logic [31:0] INCM  = 32'h8,  INCD  = 32'h10, SWSEL = 32'h20;
    localparam logic [31:0] U1 = 32'h100, U2 = 32'h200, U4 = 32'h400, ABRT = 32'h10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = 32'd0;
    logic        m_err = 1'b0;
    logic        dev_req = 1'b0;
    logic        dev_term = 1'b0;
    logic        irq;

    logic [7:0]  mem [0:511];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = 32'd0;
    int          checks = 0;
    int          errors = 0;

    always #5ns clk = ~clk;

    xfer_channel u_xfer_channel (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_ack(m_ack),
        .m_rdata(m_rdata), .m_err(m_err), .dev_req(dev_req), .dev_term(dev_term),
        .irq(irq)
    );

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd2) ? 4 : (s == 2'd1) ? 2 : 1;
    endfunction

    // bus slave: acknowledge one cycle after a request, commit writes on the ack edge
    always @(posedge clk) begin
        if (rst) begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
        end else begin
            if (m_req && m_we && m_ack && !m_err)
                for (int k = 0; k < nbytes(m_size); k++)
                    mem[(m_addr[8:0] + 9'(k))] <= m_wdata[8*k +: 8];
            if (m_req && !m_ack) begin
                m_ack <= 1'b1;
                m_err <= err_en && (m_addr == err_addr);
                for (int k = 0; k < 4; k++)
                    m_rdata[8*k +: 8] <= (k < nbytes(m_size)) ? mem[(m_addr[8:0] + 9'(k))] : 8'h00;
            end else begin
                m_ack <= 1'b0;
                m_err <= 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        logic        still;
        still = 1'b1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            reg_rd(3'd3, v);
            if (!v[17]) begin still = 1'b0; break; end
        end
        chk({tag, " channel idle"}, {31'd0, still}, 32'd0);
    endtask

    task automatic setup(input logic [31:0] mp, ml, dp, cv, ie);
        reg_wr(3'd5, 32'hF);
        reg_wr(3'd0, mp);
        reg_wr(3'd1, ml);
        reg_wr(3'd2, dp);
        reg_wr(3'd6, ie);
        reg_wr(3'd4, 32'd1);
        reg_wr(3'd3, cv);
    endtask

    task automatic pulse_req();
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); dev_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), v);
            chk("R7 R9 reset register value", v, 32'd0);
        end
        chk("R10 no request after reset", {31'd0, m_req}, 32'd0);
        chk("R8 irq low after reset", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_sw_m2d_word();
        logic [31:0] v;
        clr_mem();
        for (int i = 0; i < 8; i++) mem[9'h10 + 9'(i)] = 8'hA0 + 8'(i);
        setup(32'h10, 32'h18, 32'h100, RUNSW | SWSEL | M2D | INCM | INCD | U4, 32'h1);
        wait_idle("R1");
        for (int i = 0; i < 8; i++)
            chk("R2 memory-to-device data", {24'd0, mem[9'h100 + 9'(i)]}, 32'hA0 + i);
        reg_rd(3'd5, v); chk("R1 done status only", v, 32'h4);
        reg_rd(3'd0, v); chk("R1 pointer reached limit", v, 32'h18);
        reg_rd(3'd2, v); chk("R3 device pointer advanced", v, 32'h108);
        reg_rd(3'd3, v); chk("R1 run bits cleared", v & 32'h3, 32'h0);
        reg_rd(3'd7, v); chk("R9 nothing remaining", v, 32'h0);
        chk("R8 done raises irq", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_d2m_fixed_odd_unit();
        logic [31:0] v;
        clr_mem();
        mem[9'h140] = 8'h5C;
        mem[9'h141] = 8'hEE;
        setup(32'h20, 32'h24, 32'h140, RUNSW | SWSEL | INCM | 32'h300, 32'h0);
        wait_idle("R2");
        for (int i = 0; i < 4; i++)
            chk("R2 R4 device-to-memory single byte", {24'd0, mem[9'h20 + 9'(i)]}, 32'h5C);
        reg_rd(3'd2, v); chk("R3 fixed device pointer", v, 32'h140);
        reg_rd(3'd0, v); chk("R4 one-byte step", v, 32'h24);
        chk("R8 irq masked", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_half_fixed_dev();
        logic [31:0] v;
        clr_mem();
        for (int i = 0; i < 6; i++) mem[9'h30 + 9'(i)] = 8'h11 + 8'(i);
        setup(32'h30, 32'h36, 32'h180, RUNSW | SWSEL | M2D | INCM | U2, 32'h0);
        wait_idle("R4");
        chk("R4 last halfword low byte", {24'd0, mem[9'h180]}, 32'h15);
        chk("R4 last halfword high byte", {24'd0, mem[9'h181]}, 32'h16);
        chk("R4 no byte past the unit", {24'd0, mem[9'h182]}, 32'h0);
        reg_rd(3'd0, v); chk("R4 two-byte steps", v, 32'h36);
    endtask

    task automatic t_hw_paced();
        logic [31:0] v;
        clr_mem();
        for (int i = 0; i < 3; i++) mem[9'h40 + 9'(i)] = 8'h71 + 8'(i);
        setup(32'h40, 32'h43, 32'h1C0, RUNHW | RUNSW | M2D | INCM | INCD | U1, 32'h0);
        idle_cycles(10);
        reg_rd(3'd3, v); chk("R5 busy waiting for request", {31'd0, v[17]}, 32'd1);
        reg_rd(3'd0, v); chk("R5 no unit without request", v, 32'h40);
        pulse_req(); idle_cycles(12);
        reg_rd(3'd0, v); chk("R5 one unit per request", v, 32'h41);
        pulse_req(); idle_cycles(12);
        pulse_req();
        wait_idle("R5");
        reg_rd(3'd5, v); chk("R5 done without overflow", v, 32'h4);
        chk("R5 paced data", {24'd0, mem[9'h1C2]}, 32'h73);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        clr_mem();
        setup(32'h40, 32'h44, 32'h1C0, RUNHW | M2D | INCM | U1, 32'h3);
        idle_cycles(3);
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); dev_req = 1'b0;
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); dev_req = 1'b0;
        idle_cycles(12);
        reg_rd(3'd5, v); chk("R12 overflow status", v, 32'h2);
        reg_rd(3'd0, v); chk("R12 no extra unit", v, 32'h41);
        chk("R8 overflow does not raise irq", {31'd0, irq}, 32'd0);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd4, 32'h0);
    endtask

    task automatic t_terminate();
        logic [31:0] v;
        clr_mem();
        setup(32'h50, 32'h54, 32'h1C0, RUNHW | M2D | INCM | U1, 32'h3);
        pulse_req(); idle_cycles(12);
        @(negedge clk); dev_term = 1'b1;
        @(negedge clk); dev_term = 1'b0;
        idle_cycles(2);
        reg_rd(3'd3, v); chk("R13 busy dropped", {31'd0, v[17]}, 32'd0);
        reg_rd(3'd5, v); chk("R13 terminate status only", v, 32'h8);
        reg_rd(3'd7, v); chk("R9 bytes left after terminate", v, 32'h3);
        chk("R8 terminate does not raise irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        clr_mem();
        setup(32'h60, 32'h80, 32'h1E0, RUNSW | SWSEL | M2D | INCM | U4, 32'h0);
        idle_cycles(6);
        reg_wr(3'd3, RUNSW | SWSEL | M2D | INCM | U4 | ABRT);
        wait_idle("R6");
        reg_rd(3'd5, v); chk("R6 abort sets no status", v, 32'h0);
        reg_rd(3'd0, v);
        chk("R6 stopped part way", {31'd0, (v > 32'h60 && v < 32'h80)}, 32'd1);
        chk("R6 stopped on unit boundary", v & 32'h3, 32'h0);
        reg_rd(3'd3, v); chk("R6 run bits cleared", v & 32'h3, 32'h0);
    endtask

    task automatic t_deactivate();
        logic [31:0] v;
        clr_mem();
        setup(32'h60, 32'h80, 32'h1F0, RUNSW | SWSEL | M2D | INCM | U1, 32'h0);
        idle_cycles(5);
        reg_wr(3'd4, 32'h0);
        @(negedge clk);
        chk("R10 request dropped", {31'd0, m_req}, 32'd0);
        reg_rd(3'd3, v); chk("R10 busy cleared", {31'd0, v[17]}, 32'd0);
        reg_rd(3'd7, v);
        chk("R10 transfer left incomplete", {31'd0, (v > 0 && v < 32'h20)}, 32'd1);
        idle_cycles(5);
        chk("R10 no request while inactive", {31'd0, m_req}, 32'd0);
        reg_wr(3'd4, 32'h1);
        wait_idle("R10");
        reg_rd(3'd5, v); chk("R10 resumed to done", v, 32'h4);
    endtask

    task automatic t_halt_runbits();
        logic [31:0] v;
        clr_mem();
        setup(32'h60, 32'h80, 32'h1F0, RUNSW | SWSEL | M2D | INCM | U1, 32'h0);
        idle_cycles(5);
        reg_wr(3'd3, SWSEL | M2D | INCM | U1);
        @(negedge clk);
        chk("R5 halt drops request", {31'd0, m_req}, 32'd0);
        reg_rd(3'd3, v); chk("R5 halt clears busy", {31'd0, v[17]}, 32'd0);
        reg_rd(3'd5, v); chk("R5 halt sets no status", v, 32'h0);
    endtask

    task automatic t_bus_error();
        logic [31:0] v;
        clr_mem();
        for (int i = 0; i < 4; i++) mem[9'h90 + 9'(i)] = 8'hC0 + 8'(i);
        err_en = 1'b1; err_addr = 32'h92;
        setup(32'h90, 32'h94, 32'h1A0, RUNSW | SWSEL | M2D | INCM | INCD | U1, 32'h2);
        wait_idle("R11");
        err_en = 1'b0;
        reg_rd(3'd5, v); chk("R11 bus error status only", v, 32'h1);
        reg_rd(3'd0, v); chk("R11 pointer not advanced", v, 32'h92);
        chk("R11 earlier units written", {24'd0, mem[9'h1A1]}, 32'hC1);
        chk("R8 bus error raises irq", {31'd0, irq}, 32'd1);
        reg_wr(3'd5, 32'h4);
        reg_rd(3'd5, v); chk("R7 clear of other bit keeps status", v, 32'h1);
        reg_wr(3'd5, 32'h1);
        reg_rd(3'd5, v); chk("R7 write one clears", v, 32'h0);
        chk("R8 irq follows status", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_remaining();
        logic [31:0] v;
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd0, 32'h200);
        reg_wr(3'd1, 32'h180);
        reg_rd(3'd7, v); chk("R9 pointer past limit reads zero", v, 32'h0);
        reg_wr(3'd0, 32'h100);
        reg_rd(3'd7, v); chk("R9 limit minus pointer", v, 32'h80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_m2d_word();
        t_d2m_fixed_odd_unit();
        t_half_fixed_dev();
        t_hw_paced();
        t_overflow();
        t_terminate();
        t_abort();
        t_deactivate();
        t_halt_runbits();
        t_bus_error();
        t_remaining();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule